// File: doc/BRIEF.md
# PCI Express Root Port PME Status Tracker

This block collects power-management event (PME) messages arriving at a group of PCI Express root ports and reports them to software. Each arrival carries a 16-bit requester ID. Every port keeps one PME under report and can hold one more queued behind it. Arrivals beyond that are discarded. Software reads a 32-bit status word per port. It retires the reported event by writing a one to the status flag. When a queued event exists, the hardware presents it at once.

For the path that does not use MSI, the status flags of all ports are OR-ed together. A transition of that combined level produces a single one-cycle message toward the I/O hub: an assert message when the first flag sets, and a deassert message once every flag has cleared. Messages are produced only while the global PME interrupt enable is high.

Top module: `pme_status_tracker`

## Requirements
- R1: The status word of each port has the requester ID in bits 15:0, the status flag in bit 16 and the pending flag in bit 17. Bits 31:18 always read zero. After reset every word reads zero and no message is issued.
- R2: A PME arriving at a port whose status flag is clear sets the flag and loads its requester ID into bits 15:0. The word is readable from the cycle after the arrival edge.
- R3: A write to a port with bit 16 set clears that port's status flag. A write with bit 16 at zero, a write to a port index of 6 or above, and write data in any other bit all leave every status word unchanged.
- R4: The pending flag reads 1 exactly when a PME is queued behind the one being reported.
- R5: Clearing the status flag while an event is queued sets the flag again in the same update. It loads the queued requester ID and clears the pending flag.
- R6: A PME arriving while a port already holds a reported and a queued event is discarded. It leaves both requester IDs and both flags unchanged.
- R7: When a clear and a new arrival hit the same port in one cycle, the queued event is promoted first. The arrival is then placed in the freed queue slot, or it becomes the reported event if nothing was queued.
- R8: When the OR of all status flags goes from all-clear to any-set, msg_valid pulses for one cycle with msg_deassert=0. When the OR returns to all-clear, msg_valid pulses for one cycle with msg_deassert=1. A level that stays set causes no further message. The message appears one cycle after the status change becomes visible.
- R9: No message is issued while pme_en is 0. A pending transition is reported once pme_en returns to 1.
- R10: Ports queue, clear and report independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pme_en | input | 1 | Global PME interrupt message enable |
| pme_valid | input | NPORTS | Per-port PME arrival strobe |
| pme_rid | input | 16*NPORTS | Per-port requester ID; port p uses bits 16p+15:16p |
| csr_wr | input | 1 | Status word write strobe |
| csr_port | input | PW | Port index of the write |
| csr_wdata | input | 32 | Write data; bit 16 set clears the status flag |
| csr_rd_port | input | PW | Port index whose status word is read |
| csr_rdata | output | 32 | Status word of the selected port (zero for an absent port) |
| msg_valid | output | 1 | One-cycle message pulse toward the I/O hub |
| msg_deassert | output | 1 | Message type: 0 assert, 1 deassert |

## Verification
The bench targets the case where a third PME reaches a full port. A design that overwrote the queued entry instead of discarding it would report the wrong requester ID after the next clear. It drives a clear and an arrival into the same port in one cycle. There, a design that let the arrival win would lose the queued event or reorder the IDs. It checks that a clear with a queued event keeps the OR level high and sends no deassert, and a design that treated the combined level as a level interrupt would repeat assert messages. It also holds the enable low across a status change. A design that latched the edge while disabled, or dropped it entirely, would misreport once the enable returns.

// File: rtl/pme_pkg.sv
`timescale 1ns/1ps
package pme_pkg;
    localparam int RID_W    = 16;
    localparam int WORD_W   = 32;
    localparam int STAT_BIT = 16;
    localparam int PEND_BIT = 17;

    typedef struct packed {
        logic             stat;
        logic [RID_W-1:0] rid;
        logic             pv;
        logic [RID_W-1:0] prid;
    } port_st_t;

    typedef struct packed {
        logic asrt;
        logic mv;
        logic mt;
    } msg_st_t;
endpackage

// File: rtl/pme_port_queue.sv
`timescale 1ns/1ps
module pme_port_queue
    import pme_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arr_i,
    input  logic [RID_W-1:0] arr_rid_i,
    input  logic             clr_i,
    output logic             stat_o,
    output logic             pend_o,
    output logic [RID_W-1:0] rid_o
);
    port_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        // software clear first; promote queued entry if present
        if (clr_i && st_q.stat) begin
            if (st_q.pv) begin
                st_d.rid = st_q.prid;
                st_d.pv  = 1'b0;
            end else begin
                st_d.stat = 1'b0;
            end
        end
        // arrival lands in whatever slot is free after the clear
        if (arr_i) begin
            if (!st_d.stat) begin
                st_d.stat = 1'b1;
                st_d.rid  = arr_rid_i;
            end else if (!st_d.pv) begin
                st_d.pv   = 1'b1;
                st_d.prid = arr_rid_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign pend_o = st_q.pv;
    assign rid_o  = st_q.rid;

    p_pend_needs_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pv |-> st_q.stat);

    p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && st_q.stat && st_q.pv) |=> (st_q.stat && st_q.rid == $past(st_q.prid)));

    p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat && st_q.pv && arr_i && !clr_i) |=>
        (st_q.stat && st_q.pv && $stable(st_q.rid) && $stable(st_q.prid)));

    p_hold_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat && !clr_i) |=> (st_q.stat && $stable(st_q.rid)));

    p_refill_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && st_q.stat && st_q.pv && arr_i) |=>
        (st_q.pv && st_q.prid == $past(arr_rid_i)));
endmodule

// File: rtl/pme_msg_gen.sv
`timescale 1ns/1ps
module pme_msg_gen
    import pme_pkg::*;
#(
    parameter int NPORTS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [NPORTS-1:0] stat_i,
    output logic              mv_o,
    output logic              mt_o
);
    msg_st_t st_q, st_d;
    logic    any_set;

    assign any_set = |stat_i;

    always_comb begin
        st_d    = st_q;
        st_d.mv = 1'b0;
        if (en_i) begin
            if (any_set && !st_q.asrt) begin
                st_d.mv   = 1'b1;
                st_d.mt   = 1'b0;
                st_d.asrt = 1'b1;
            end else if (!any_set && st_q.asrt) begin
                st_d.mv   = 1'b1;
                st_d.mt   = 1'b1;
                st_d.asrt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mv_o = st_q.mv;
    assign mt_o = st_q.mt;

    p_assert_on_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_o && !mt_o) |-> $past(any_set));

    p_deassert_on_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_o && mt_o) |-> !$past(any_set));

    p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mv_o |-> $past(en_i));
endmodule

// File: rtl/pme_status_tracker.sv
`timescale 1ns/1ps
module pme_status_tracker
    import pme_pkg::*;
#(
    parameter int NPORTS = 6,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pme_en,
    input  logic [NPORTS-1:0]       pme_valid,
    input  logic [NPORTS*RID_W-1:0] pme_rid,
    input  logic                    csr_wr,
    input  logic [PW-1:0]           csr_port,
    input  logic [WORD_W-1:0]       csr_wdata,
    input  logic [PW-1:0]           csr_rd_port,
    output logic [WORD_W-1:0]       csr_rdata,
    output logic                    msg_valid,
    output logic                    msg_deassert
);
    localparam int RSVD_W = WORD_W - PEND_BIT - 1;

    logic [NPORTS-1:0] stat_w;
    logic [NPORTS-1:0] pend_w;
    logic [NPORTS-1:0] clr_w;
    logic [RID_W-1:0]  rid_w [NPORTS];
    logic              unused_wdata;

    assign unused_wdata = ^{csr_wdata[WORD_W-1:STAT_BIT+1], csr_wdata[STAT_BIT-1:0]};

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign clr_w[g] = csr_wr && (csr_port == PW'(g)) && csr_wdata[STAT_BIT];

        pme_port_queue u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .arr_i     (pme_valid[g]),
            .arr_rid_i (pme_rid[g*RID_W +: RID_W]),
            .clr_i     (clr_w[g]),
            .stat_o    (stat_w[g]),
            .pend_o    (pend_w[g]),
            .rid_o     (rid_w[g])
        );
    end

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (csr_rd_port == PW'(i)) begin
                csr_rdata = {{RSVD_W{1'b0}}, pend_w[i], stat_w[i], rid_w[i]};
            end
        end
    end

    pme_msg_gen #(.NPORTS(NPORTS)) u_msg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (pme_en),
        .stat_i (stat_w),
        .mv_o   (msg_valid),
        .mt_o   (msg_deassert)
    );

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[WORD_W-1:PEND_BIT+1] == '0);

    p_ignored_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_wr || !csr_wdata[STAT_BIT]) |-> (clr_w == '0));
endmodule

// File: tb/pme_status_tracker_test.sv
`timescale 1ns/1ps
module pme_status_tracker_test;
    localparam int  NP     = 6;
    localparam int  PW     = 3;
    localparam time PERIOD = 20;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pme_en;
    logic [NP-1:0] pme_valid;
    logic [NP*16-1:0] pme_rid;
    logic          csr_wr;
    logic [PW-1:0] csr_port;
    logic [31:0]   csr_wdata;
    logic [PW-1:0] csr_rd_port;
    logic [31:0]   csr_rdata;
    logic          msg_valid;
    logic          msg_deassert;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    bit        m_stat [NP];
    bit [15:0] m_rid  [NP];
    bit        m_pv   [NP];
    bit [15:0] m_prid [NP];
    bit        m_asrt, m_mv, m_mt;

    always #(PERIOD/2) clk = ~clk;

    pme_status_tracker #(.NPORTS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .pme_en(pme_en), .pme_valid(pme_valid),
        .pme_rid(pme_rid), .csr_wr(csr_wr), .csr_port(csr_port),
        .csr_wdata(csr_wdata), .csr_rd_port(csr_rd_port), .csr_rdata(csr_rdata),
        .msg_valid(msg_valid), .msg_deassert(msg_deassert)
    );

    function automatic bit [31:0] exp_word(int p);
        return {14'b0, m_pv[p], m_stat[p], m_rid[p]};
    endfunction

    task automatic check32(string req, string what, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int p = 0; p < 8; p++) begin
            csr_rd_port = PW'(p);
            #1;
            check32(req, $sformatf("word port %0d", p), csr_rdata,
                    (p < NP) ? exp_word(p) : 32'h0);
        end
        check32(req, "msg_valid", {31'b0, msg_valid}, {31'b0, m_mv});
        if (m_mv) check32(req, "msg_deassert", {31'b0, msg_deassert}, {31'b0, m_mt});
    endtask

    task automatic idle_inputs();
        pme_valid = '0;
        pme_rid   = '0;
        csr_wr    = 1'b0;
        csr_port  = '0;
        csr_wdata = '0;
    endtask

    task automatic model_step();
        bit any_now = 0;
        for (int p = 0; p < NP; p++) any_now |= m_stat[p];
        m_mv = 0;
        if (pme_en) begin
            if (any_now && !m_asrt) begin m_mv = 1; m_mt = 0; m_asrt = 1; end
            else if (!any_now && m_asrt) begin m_mv = 1; m_mt = 1; m_asrt = 0; end
        end
        for (int p = 0; p < NP; p++) begin
            if (csr_wr && csr_port == PW'(p) && csr_wdata[16] && m_stat[p]) begin
                if (m_pv[p]) begin m_rid[p] = m_prid[p]; m_pv[p] = 0; end
                else m_stat[p] = 0;
            end
            if (pme_valid[p]) begin
                if (!m_stat[p]) begin m_stat[p] = 1; m_rid[p] = pme_rid[p*16 +: 16]; end
                else if (!m_pv[p]) begin m_pv[p] = 1; m_prid[p] = pme_rid[p*16 +: 16]; end
            end
        end
    endtask

    // inputs are set at a falling edge before the call
    task automatic tick(string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check_all(req);
    endtask

    task automatic arrive(int p, bit [15:0] id);
        pme_valid[p] = 1'b1;
        pme_rid[p*16 +: 16] = id;
    endtask

    task automatic wr(int p, bit [31:0] d);
        csr_wr = 1'b1; csr_port = PW'(p); csr_wdata = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; pme_en = 1'b1; csr_rd_port = '0;
        idle_inputs();
        for (int p = 0; p < NP; p++) begin m_stat[p]=0; m_rid[p]=0; m_pv[p]=0; m_prid[p]=0; end
        m_asrt = 0; m_mv = 0; m_mt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2 first arrival; R8 assert follows a cycle later
        arrive(0, 16'h1111); tick("R2 load");
        tick("R8 assert pulse");
        tick("R8 no repeat");
        // R4 queued entry
        arrive(0, 16'h2222); tick("R4 pending set");
        // R6 third arrival dropped
        arrive(0, 16'h3333); tick("R6 drop when full");
        // R3 writes that must not clear
        wr(0, 32'hFFFE_FFFF); tick("R3 write zero bit16");
        wr(6, 32'h0001_0000); tick("R3 absent port");
        wr(1, 32'h0001_0000); tick("R3 other port");
        // R5 clear with refill: level stays high, no deassert
        wr(0, 32'h0001_0000); tick("R5 refill");
        tick("R5 refill no message");
        // R7 same-cycle clear plus arrival
        arrive(0, 16'h4444); tick("R4 pending again");
        wr(0, 32'h0001_0000); arrive(0, 16'h5555); tick("R7 refill first");
        wr(0, 32'h0001_0000); tick("R7 order next id");
        wr(0, 32'h0001_0000); tick("R8 status cleared");
        tick("R8 deassert pulse");
        tick("R8 quiet");
        // R7 clear with no queue plus arrival
        arrive(2, 16'hAAAA); tick("R10 port2 load");
        wr(2, 32'h0001_0000); arrive(2, 16'hBBBB); tick("R7 clear then arrival");
        wr(2, 32'h0001_0000); tick("R8 clear port2");
        tick("R8 deassert port2");
        // R9 enable gate
        pme_en = 1'b0; arrive(3, 16'h0C0C); tick("R9 disabled arrival");
        tick("R9 no message");
        tick("R9 still none");
        pme_en = 1'b1; tick("R9 enable returns");
        tick("R9 assert after enable");
        wr(3, 32'h0001_0000); tick("R9 clear");
        tick("R9 deassert");

        // R10 constrained random traffic across ports
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < NP; p++)
                if ($urandom_range(3) == 0) arrive(p, 16'($urandom));
            if ($urandom_range(2) == 0)
                wr(int'($urandom_range(7)), {$urandom} | (($urandom_range(3) != 0) ? 32'h0001_0000 : 32'h0));
            if ($urandom_range(63) == 0) pme_en = ~pme_en;
            tick("R10 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule